// File: doc/BRIEF.md
# Interval Mask Tile Classifier

This block decides how an attention-score tile is to be masked before the score pipeline touches it. A tile spans `TILE_ROWS` consecutive query rows and `TILE_COLS` consecutive key columns. The mask is not stored as a dense matrix. Each key column instead owns a few row intervals that mark masked-out query rows, so storage grows with the number of key columns and not with its square.

On a start pulse the block walks the tile's columns, one per clock. For each column it reads that column's intervals from an internal register file and checks them against the tile's row range. It then reports a two-bit class: fully masked (the tile can be skipped), unmasked (masking can be bypassed) or partial. For partial tiles it also reports a bitmap with one bit per element. A plain write port fills the register file.

Top module: `mask_tile_classifier`

## Requirements
- R1: An interval slot holds a start row (16 bits), an end row (16 bits) and an enable bit. It masks row r only when enabled and start <= r < end. A slot with start >= end masks nothing.
- R2: Each key column has `N_IVL` (default 4) slots. A row is masked in a column when any slot of that column masks it.
- R3: The tile rows are row_base .. row_base+TILE_ROWS-1, taken without wrap-around. A column is fully masked when all tile rows are masked in it. It is clear when none is.
- R4: class_o is 2'b10 (fully masked) only when every tile column is fully masked.
- R5: class_o is 2'b00 (unmasked) only when every tile column is clear.
- R6: In every other case class_o is 2'b01 (partial).
- R7: For a partial tile, bit c*TILE_ROWS+r of bitmap_o is set when tile row r is masked in tile column c. bitmap_o is all zero for the other two classes.
- R8: start_i is sampled on a rising edge while the block is idle. One column is evaluated per cycle. done_o is high for exactly one cycle, TILE_COLS edges after the start edge. class_o and bitmap_o are valid from that cycle on and hold until the next result.
- R9: start_i is ignored while busy_o is high. The running tile's result is not changed, and no extra result is produced.
- R10: After reset, done_o, busy_o, class_o and bitmap_o are zero and every interval slot is disabled.
- R11: Tile column c reads key column (col_base_i + c) modulo NUM_COLS, where NUM_COLS is a power of two.
- R12: A write (wr_en_i) replaces one slot (wr_col_i, wr_slot_i) on the next edge. Later tiles see the new value. The store holds NUM_COLS*N_IVL slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Interval slot write strobe |
| wr_col_i | input | log2(NUM_COLS) | Key column to write |
| wr_slot_i | input | log2(N_IVL) | Slot within the column |
| wr_lo_i | input | 16 | Interval start row (inclusive) |
| wr_hi_i | input | 16 | Interval end row (exclusive) |
| wr_on_i | input | 1 | Interval enable |
| start_i | input | 1 | Start classifying a tile |
| row_base_i | input | 16 | First query row of the tile |
| col_base_i | input | log2(NUM_COLS) | First key column of the tile |
| busy_o | output | 1 | Tile walk in progress |
| done_o | output | 1 | One-cycle result pulse |
| class_o | output | 2 | Tile class: 00 unmasked, 01 partial, 10 fully masked |
| bitmap_o | output | TILE_ROWS*TILE_COLS | Per-element mask, set = masked |

## Verification
The start edge is counted as edge zero, and done_o is due on edge TILE_COLS after it. The bench drives and samples on falling edges and counts the falling edges that pass between releasing start_i and seeing done_o; for the default four columns that count must be exactly four. Class and bitmap are read in that same half cycle and are read again several cycles later to confirm that they hold. A slot write lands on the edge after it is driven, so every tile start is driven only after the write strobe has been released.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int ROW_W = 16;

  typedef struct packed {
    logic             on;
    logic [ROW_W-1:0] lo;
    logic [ROW_W-1:0] hi;
  } ivl_t;

  typedef enum logic [1:0] {
    CLS_CLEAR = 2'b00,
    CLS_PART  = 2'b01,
    CLS_FULL  = 2'b10
  } tile_cls_e;
endpackage

// File: rtl/mtc_ivl_store.sv
module mtc_ivl_store
  import mtc_pkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int N_IVL    = 4,
  localparam int COL_AW  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SLOT_W  = (N_IVL > 1) ? $clog2(N_IVL) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [COL_AW-1:0]       wr_col_i,
  input  logic [SLOT_W-1:0]       wr_slot_i,
  input  ivl_t                    wr_ivl_i,
  input  logic [COL_AW-1:0]       rd_col_i,
  output ivl_t [N_IVL-1:0]        rd_ivls_o
);
  ivl_t mem_q [NUM_COLS][N_IVL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_COLS; c++)
        for (int s = 0; s < N_IVL; s++)
          mem_q[c][s] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_col_i][wr_slot_i] <= wr_ivl_i;
    end
  end

  always_comb begin
    for (int s = 0; s < N_IVL; s++)
      rd_ivls_o[s] = mem_q[rd_col_i][s];
  end

  // R12: a written slot reads back on the next cycle
  a_r12_wr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_col_i)][$past(wr_slot_i)] == $past(wr_ivl_i));
endmodule

// File: rtl/mtc_col_eval.sv
module mtc_col_eval
  import mtc_pkg::*;
#(
  parameter int N_IVL     = 4,
  parameter int TILE_ROWS = 4
) (
  input  ivl_t [N_IVL-1:0]     ivls_i,
  input  logic [ROW_W-1:0]     row_base_i,
  output logic [TILE_ROWS-1:0] row_mask_o,
  output logic                 col_full_o,
  output logic                 col_clear_o
);
  localparam int RW1 = ROW_W + 1;

  // rows are widened by one bit so the tile never wraps past the top row
  for (genvar r = 0; r < TILE_ROWS; r++) begin : g_row
    logic [RW1-1:0] row;
    assign row = {1'b0, row_base_i} + RW1'(r);
    always_comb begin
      row_mask_o[r] = 1'b0;
      for (int s = 0; s < N_IVL; s++)
        if (ivls_i[s].on && ({1'b0, ivls_i[s].lo} <= row) && (row < {1'b0, ivls_i[s].hi}))
          row_mask_o[r] = 1'b1;
    end
  end

  assign col_full_o  = &row_mask_o;
  assign col_clear_o = ~|row_mask_o;
endmodule

// File: rtl/mtc_tile_seq.sv
module mtc_tile_seq
  import mtc_pkg::*;
#(
  parameter int TILE_ROWS = 4,
  parameter int TILE_COLS = 4,
  parameter int COL_AW    = 4,
  localparam int CIDX_W   = (TILE_COLS > 1) ? $clog2(TILE_COLS) : 1,
  localparam int BM_W     = TILE_ROWS * TILE_COLS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ROW_W-1:0]     row_base_i,
  input  logic [COL_AW-1:0]    col_base_i,
  input  logic [TILE_ROWS-1:0] row_mask_i,
  input  logic                 col_full_i,
  input  logic                 col_clear_i,
  output logic [ROW_W-1:0]     row_base_o,
  output logic [COL_AW-1:0]    rd_col_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [1:0]           class_o,
  output logic [BM_W-1:0]      bitmap_o
);
  logic              busy_q, done_q;
  logic [CIDX_W-1:0] cidx_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_AW-1:0] colb_q;
  logic              all_full_q, all_clear_q;
  logic [BM_W-1:0]   bm_acc_q, bm_next, bm_q;
  tile_cls_e         cls_q, cls_next;
  logic              full_n, clear_n, last;

  assign full_n  = all_full_q & col_full_i;
  assign clear_n = all_clear_q & col_clear_i;
  assign last    = (cidx_q == CIDX_W'(TILE_COLS - 1));

  always_comb begin
    bm_next = bm_acc_q;
    bm_next[int'(cidx_q)*TILE_ROWS +: TILE_ROWS] = row_mask_i;
    if (full_n)       cls_next = CLS_FULL;
    else if (clear_n) cls_next = CLS_CLEAR;
    else              cls_next = CLS_PART;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      cidx_q      <= '0;
      row_q       <= '0;
      colb_q      <= '0;
      all_full_q  <= 1'b0;
      all_clear_q <= 1'b0;
      bm_acc_q    <= '0;
      bm_q        <= '0;
      cls_q       <= CLS_CLEAR;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q      <= 1'b1;
          cidx_q      <= '0;
          row_q       <= row_base_i;
          colb_q      <= col_base_i;
          all_full_q  <= 1'b1;
          all_clear_q <= 1'b1;
          bm_acc_q    <= '0;
        end
      end else begin
        all_full_q  <= full_n;
        all_clear_q <= clear_n;
        bm_acc_q    <= bm_next;
        cidx_q      <= cidx_q + CIDX_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cls_q  <= cls_next;
          bm_q   <= (cls_next == CLS_PART) ? bm_next : '0;
        end
      end
    end
  end

  assign row_base_o = row_q;
  assign rd_col_o   = colb_q + COL_AW'(cidx_q);
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign class_o    = cls_q;
  assign bitmap_o   = bm_q;

  // latency counter kept only for the checks below
  int unsigned lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= 0;
    else if (!busy_q && start_i) lat_q <= 0;
    else if (busy_q)            lat_q <= lat_q + 1;
  end

  // R8: result arrives TILE_COLS edges after the start edge
  a_r8_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == TILE_COLS);
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4 R5 R6: only the three legal class codes appear
  a_r6_cls_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o != 2'b11);
  // R7: bitmap is empty unless the tile is partial
  a_r7_bm_only_part: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o != CLS_PART |-> bitmap_o == '0);
  // R9: a start seen while busy does not restart the walk
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last |=> busy_o && $stable(row_q) && $stable(colb_q));
endmodule

// File: rtl/mask_tile_classifier.sv
module mask_tile_classifier
  import mtc_pkg::*;
#(
  parameter int NUM_COLS  = 16,
  parameter int N_IVL     = 4,
  parameter int TILE_ROWS = 4,
  parameter int TILE_COLS = 4,
  localparam int COL_AW   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SLOT_W   = (N_IVL > 1) ? $clog2(N_IVL) : 1,
  localparam int BM_W     = TILE_ROWS * TILE_COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [COL_AW-1:0] wr_col_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [ROW_W-1:0]  wr_lo_i,
  input  logic [ROW_W-1:0]  wr_hi_i,
  input  logic              wr_on_i,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_base_i,
  input  logic [COL_AW-1:0] col_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        class_o,
  output logic [BM_W-1:0]   bitmap_o
);
  ivl_t                 wr_ivl;
  ivl_t [N_IVL-1:0]     rd_ivls;
  logic [COL_AW-1:0]    rd_col;
  logic [ROW_W-1:0]     row_q;
  logic [TILE_ROWS-1:0] row_mask;
  logic                 col_full, col_clear;

  assign wr_ivl = '{on: wr_on_i, lo: wr_lo_i, hi: wr_hi_i};

  mtc_ivl_store #(.NUM_COLS(NUM_COLS), .N_IVL(N_IVL)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_col_i, .wr_slot_i,
    .wr_ivl_i (wr_ivl),
    .rd_col_i (rd_col),
    .rd_ivls_o(rd_ivls)
  );

  mtc_col_eval #(.N_IVL(N_IVL), .TILE_ROWS(TILE_ROWS)) u_eval (
    .ivls_i     (rd_ivls),
    .row_base_i (row_q),
    .row_mask_o (row_mask),
    .col_full_o (col_full),
    .col_clear_o(col_clear)
  );

  mtc_tile_seq #(.TILE_ROWS(TILE_ROWS), .TILE_COLS(TILE_COLS), .COL_AW(COL_AW)) u_seq (
    .clk_i, .rst_ni, .start_i, .row_base_i, .col_base_i,
    .row_mask_i (row_mask),
    .col_full_i (col_full),
    .col_clear_i(col_clear),
    .row_base_o (row_q),
    .rd_col_o   (rd_col),
    .busy_o, .done_o, .class_o, .bitmap_o
  );
endmodule

// File: tb/mask_tile_classifier_test.sv
module mask_tile_classifier_test;
  localparam int NC = 16, NI = 4, TR = 4, TC = 4;
  localparam int NV = 14;
  // {row_base, col_base, class, bitmap}
  localparam logic [37:0] VEC [NV] = '{
    {16'd0,     4'd0,  2'b01, 16'hF0FF},
    {16'd0,     4'd4,  2'b00, 16'h0000},
    {16'd60,    4'd12, 2'b10, 16'h0000},
    {16'd10,    4'd0,  2'b01, 16'hF3FF},
    {16'd48,    4'd1,  2'b01, 16'h0F0F},
    {16'd6,     4'd12, 2'b01, 16'hF9FF},
    {16'd0,     4'd14, 2'b10, 16'h0000},
    {16'd97,    4'd0,  2'b01, 16'h7077},
    {16'd100,   4'd8,  2'b00, 16'h0000},
    {16'd20,    4'd2,  2'b01, 16'h00F3},
    {16'd65534, 4'd0,  2'b00, 16'h0000},
    {16'd12,    4'd2,  2'b01, 16'h00F0},
    {16'd9,     4'd2,  2'b01, 16'h00F6},
    {16'd3,     4'd8,  2'b01, 16'hF0FF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_on = 1'b0, start = 1'b0;
  logic [3:0] wr_col = '0, col_base = '0;
  logic [1:0] wr_slot = '0;
  logic [15:0] wr_lo = '0, wr_hi = '0, row_base = '0;
  logic busy, done;
  logic [1:0] cls;
  logic [15:0] bm;
  int checks = 0, fails = 0;
  int lat;

  always #2 clk = ~clk;

  mask_tile_classifier #(.NUM_COLS(NC), .N_IVL(NI), .TILE_ROWS(TR), .TILE_COLS(TC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_col_i(wr_col), .wr_slot_i(wr_slot),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_on_i(wr_on), .start_i(start),
    .row_base_i(row_base), .col_base_i(col_base), .busy_o(busy), .done_o(done),
    .class_o(cls), .bitmap_o(bm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input int s, input int lo, input int hi, input logic on);
    @(negedge clk);
    wr_en = 1'b1; wr_col = 4'(c); wr_slot = 2'(s);
    wr_lo = 16'(lo); wr_hi = 16'(hi); wr_on = on;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // start a tile and count falling edges until done_o
  task automatic run(input int rb, input int cb);
    @(negedge clk);
    start = 1'b1; row_base = 16'(rb); col_base = 4'(cb);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done", 32'(done), 0);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 class", 32'(cls), 0);
    chk("R10 bitmap", 32'(bm), 0);
    rst_n = 1'b1;
    // R10: store comes up disabled, so a fresh tile is unmasked
    run(0, 0);
    chk("R10 empty store class", 32'(cls), 0);

    // R1 R2: program the store (including empty and disabled slots)
    wr(0, 0, 0, 100, 1);
    wr(1, 0, 0, 50, 1);  wr(1, 1, 50, 100, 1);
    wr(2, 0, 10, 12, 1); wr(2, 3, 20, 22, 1); wr(2, 1, 0, 100, 0);
    wr(3, 0, 0, 100, 1);
    wr(8, 0, 0, 100, 1);
    wr(9, 2, 0, 100, 1);
    wr(10, 0, 5, 5, 1);  wr(10, 1, 40, 2, 1);
    wr(11, 3, 0, 100, 1);
    wr(12, 0, 0, 100, 1); wr(13, 0, 0, 100, 1);
    wr(14, 0, 0, 7, 1);   wr(14, 1, 9, 100, 1);
    wr(15, 0, 0, 100, 1);

    // R1..R7, R11: vector table
    for (int i = 0; i < NV; i++) begin
      run(int'(VEC[i][37:22]), int'(VEC[i][21:18]));
      chk("R8 latency", 32'(lat), TC);
      chk("R3 R4 R5 R6 class", 32'(cls), 32'(VEC[i][17:16]));
      chk("R7 R11 bitmap", 32'(bm), 32'(VEC[i][15:0]));
    end

    // R12: new interval seen by a later tile
    wr(4, 0, 0, 100, 1);
    run(0, 4);
    chk("R12 class after write", 32'(cls), 1);
    chk("R12 bitmap after write", 32'(bm), 32'h000F);

    // R9: start during a walk is ignored
    @(negedge clk);
    start = 1'b1; row_base = 16'd0; col_base = 4'd0;
    @(negedge clk);
    row_base = 16'd60; col_base = 4'd12;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    chk("R9 latency unchanged", 32'(lat), TC);
    chk("R9 class of first tile", 32'(cls), 1);
    chk("R9 bitmap of first tile", 32'(bm), 32'hF0FF);
    begin
      int extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R9 no second result", 32'(extra), 0);
    end
    // R8: result holds after the pulse
    chk("R8 class held", 32'(cls), 1);
    chk("R8 bitmap held", 32'(bm), 32'hF0FF);

    // R12: disabling the slot restores an unmasked tile
    wr(4, 0, 0, 100, 0);
    run(0, 4);
    chk("R12 class after disable", 32'(cls), 0);
    chk("R12 bitmap after disable", 32'(bm), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule